// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence a synchronous DRAM walks through internally during one burst. A start pulse captures the starting column, a burst-length selector, an ordering selector and the access direction. From the next cycle on, the block presents the current beat's column on its output. Each advance pulse steps it to the following beat. The final beat of a finite burst is flagged.

The same block fits inside a memory device model, where it supplies the addresses the array would touch. It also fits beside a memory controller, where it predicts those addresses for comparison. A full-page burst walks every column, wraps from the top column back to zero, and runs until a stop pulse ends it. A stop pulse can also cut any shorter burst early.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `colValid` and `lastBeat` are both 0.
- R2: A `start` pulse makes `colValid` 1 and `colOut` equal to the captured `startCol` in the following cycle. This holds even when a burst is already running, which is then abandoned. `start` has priority over `stop` and `advance`.
- R3: `blSel` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The codes 4, 5 and 6 give a 1-beat burst.
- R4: In sequential order (`ilvSel`=0), beat k keeps the column bits above the low log2(BL) bits of `startCol`. Its low log2(BL) bits equal (low bits of `startCol` + k) modulo BL.
- R5: In interleaved order (`ilvSel`=1), beat k of a finite burst equals `startCol` XOR k.
- R6: `lastBeat` is 1 exactly while the final beat of a finite burst is shown. An `advance` during that beat makes `colValid` 0 in the next cycle.
- R7: A full-page burst walks the column space sequentially, wrapping from the top column to 0. It never raises `lastBeat`, and `ilvSel` has no effect on it.
- R8: A `stop` during an active burst of any length makes `colValid` 0 in the next cycle. `stop` wins over an `advance` in the same cycle.
- R9: When `isWrite`=1 and `wrSingle`=1 at start, the burst has a single beat whatever `blSel` holds. With `isWrite`=0, the programmed length applies even when `wrSingle`=1.
- R10: `advance` while no burst is active has no effect, and `colValid` stays 0.
- R11: While a burst is active and `advance`, `stop` and `start` are all 0, `colOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the values on the configuration inputs |
| startCol | input | COL_W | First column of the burst |
| blSel | input | 3 | Burst length code |
| ilvSel | input | 1 | 0 = sequential order, 1 = interleaved order |
| isWrite | input | 1 | The burst being started is a write |
| wrSingle | input | 1 | Writes use single-location accesses |
| advance | input | 1 | Step to the next beat |
| stop | input | 1 | Terminate the running burst |
| colValid | output | 1 | A burst is active and `colOut` is meaningful |
| colOut | output | COL_W | Column of the current beat |
| lastBeat | output | 1 | Current beat is the final beat of a finite burst |

## Verification
Two pairs of actions can fall in the same cycle: a terminating `stop` together with an `advance`, and a restarting `start` on top of a running burst. Both are provoked by holding `advance` high through the cycle where `stop` or `start` is raised. They are judged by whether the next cycle shows an idle output, or the newly captured start column, rather than another beat of the old sequence. A scoreboard compares every presented beat against a column list computed from the ordering rules. This covers the full-page wrap across the top column and a burst stopped mid-way.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Burst length codes on blSel
  localparam logic [2:0] BL_ONE   = 3'd0;
  localparam logic [2:0] BL_TWO   = 3'd1;
  localparam logic [2:0] BL_FOUR  = 3'd2;
  localparam logic [2:0] BL_EIGHT = 3'd3;
  localparam logic [2:0] BL_PAGE  = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

endpackage

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             ilvSel,
  input  logic             isWrite,
  input  logic             wrSingle,
  output logic [COL_W-1:0] colOut,
  output logic             isLast
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] maskR;
  logic [COL_W-1:0] cnt;
  logic             fullR;
  logic             ilvR;

  logic [COL_W-1:0] ldMask;
  logic             ldFull;

  // Length decode for the burst being loaded
  always_comb begin
    ldFull = 1'b0;
    case (blSel)
      BL_TWO:   ldMask = COL_W'(1);
      BL_FOUR:  ldMask = COL_W'(3);
      BL_EIGHT: ldMask = COL_W'(7);
      BL_PAGE: begin
        ldMask = '1;
        ldFull = 1'b1;
      end
      default:  ldMask = '0;
    endcase
    if (isWrite && wrSingle) begin
      ldMask = '0;
      ldFull = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      maskR   <= '0;
      cnt     <= '0;
      fullR   <= 1'b0;
      ilvR    <= 1'b0;
    end else if (strb.load) begin
      baseCol <= startCol;
      maskR   <= ldMask;
      cnt     <= '0;
      fullR   <= ldFull;
      ilvR    <= ilvSel;
    end else if (strb.step) begin
      cnt <= cnt + COL_W'(1);
    end
  end

  logic [COL_W-1:0] sumCol;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  always_comb begin
    sumCol = baseCol + cnt;
    seqCol = (baseCol & ~maskR) | (sumCol & maskR);
    ilvCol = baseCol ^ (cnt & maskR);
    colOut = (ilvR && !fullR) ? ilvCol : seqCol;
    isLast = !fullR && (cnt == maskR);
  end

endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      advance,
  input  logic      stop,
  input  logic      isLast,
  output dpStrobe_t strb,
  output logic      active
);

  always_comb begin
    strb.load = start;
    strb.step = active && advance && !stop && !start && !isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      active <= 1'b0;
    else if (start)
      active <= 1'b1;
    else if (active && (stop || (advance && isLast)))
      active <= 1'b0;
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blSel,
  input  logic             ilvSel,
  input  logic             isWrite,
  input  logic             wrSingle,
  input  logic             advance,
  input  logic             stop,
  output logic             colValid,
  output logic [COL_W-1:0] colOut,
  output logic             lastBeat
);

  dpStrobe_t strb;
  logic      active;
  logic      isLast;

  burst_col_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .advance (advance),
    .stop    (stop),
    .isLast  (isLast),
    .strb    (strb),
    .active  (active)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startCol (startCol),
    .blSel    (blSel),
    .ilvSel   (ilvSel),
    .isWrite  (isWrite),
    .wrSingle (wrSingle),
    .colOut   (colOut),
    .isLast   (isLast)
  );

  assign colValid = active;
  assign lastBeat = active && isLast;

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic             advance,
  input logic             stop,
  input logic             colValid,
  input logic [COL_W-1:0] colOut,
  input logic             lastBeat
);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> colValid && colOut == $past(startCol));

  p_flag_in_burst_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    colValid && lastBeat && advance && !start |=> !colValid);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    colValid && stop && !start |=> !colValid);

  p_idle_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    !colValid && !start |=> !colValid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    colValid && !advance && !stop && !start |=> colValid && $stable(colOut));

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .startCol (startCol),
  .advance  (advance),
  .stop     (stop),
  .colValid (colValid),
  .colOut   (colOut),
  .lastBeat (lastBeat)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       blSel = '0;
  logic             ilvSel = 1'b0;
  logic             isWrite = 1'b0;
  logic             wrSingle = 1'b0;
  logic             advance = 1'b0;
  logic             stop = 1'b0;
  logic             colValid;
  logic [COL_W-1:0] colOut;
  logic             lastBeat;

  int checks = 0;
  int errors = 0;
  bit monEn  = 1'b0;

  typedef struct {
    int    col;
    bit    last;
    string tag;
  } beat_t;

  beat_t sbq[$];

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .blSel(blSel), .ilvSel(ilvSel), .isWrite(isWrite), .wrSingle(wrSingle),
    .advance(advance), .stop(stop),
    .colValid(colValid), .colOut(colOut), .lastBeat(lastBeat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every active cycle with monitoring on is one presented beat
  always @(negedge clk) begin
    if (monEn && colValid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R6 extra beat", int'(colOut), -1);
      end else begin
        beat_t e;
        e = sbq.pop_front();
        chk(int'(colOut) == e.col, e.tag, int'(colOut), e.col);
        chk(lastBeat == e.last, {e.tag, " lastBeat R6"}, int'(lastBeat), int'(e.last));
      end
    end
  end

  // Driver: runs one burst with advance held high, optionally stopping it
  task automatic burst(input int sc, input logic [2:0] sel, input bit ilv,
                       input bit wr, input bit sgl, input int nReq,
                       input bit useStop, input string tag);
    int  len;
    bit  full;
    int  mask;
    int  n;
    full = (sel == 3'd7);
    case (sel)
      3'd1: len = 2;
      3'd2: len = 4;
      3'd3: len = 8;
      3'd7: len = NCOL;
      default: len = 1;
    endcase
    if (wr && sgl) begin
      len  = 1;
      full = 1'b0;
    end
    mask = len - 1;
    n = useStop ? nReq : len;
    for (int k = 0; k < n; k++) begin
      beat_t e;
      if (full)
        e.col = (sc + k) % NCOL;
      else if (ilv)
        e.col = sc ^ k;
      else
        e.col = (sc & ~mask) | ((sc + k) & mask);
      e.last = !full && (k == len - 1);
      e.tag  = tag;
      sbq.push_back(e);
    end
    @(negedge clk);
    startCol = COL_W'(sc);
    blSel    = sel;
    ilvSel   = ilv;
    isWrite  = wr;
    wrSingle = sgl;
    start    = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    advance = 1'b1;
    repeat (n - 1) @(negedge clk);
    if (useStop) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end else begin
      @(negedge clk);
    end
    advance = 1'b0;
    chk(colValid == 1'b0, {tag, " ends R6/R8"}, int'(colValid), 0);
    chk(sbq.size() == 0, {tag, " all beats seen"}, sbq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(colValid == 1'b0, "R1 colValid in reset", int'(colValid), 0);
    chk(lastBeat == 1'b0, "R1 lastBeat in reset", int'(lastBeat), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(colValid == 1'b0, "R1 idle after reset", int'(colValid), 0);

    // R10: advance while idle
    advance = 1'b1;
    repeat (3) @(negedge clk);
    chk(colValid == 1'b0, "R10 idle advance ignored", int'(colValid), 0);
    advance = 1'b0;

    monEn = 1'b1;
    burst('h0D5, 3'd0, 0, 0, 0, 0, 0, "R3 BL1 seq");
    burst('h0D5, 3'd1, 0, 0, 0, 0, 0, "R4 BL2 seq");
    burst('h0D5, 3'd2, 0, 0, 0, 0, 0, "R4 BL4 seq");
    burst('h0D5, 3'd3, 0, 0, 0, 0, 0, "R4 BL8 seq");
    burst('h1F6, 3'd2, 1, 0, 0, 0, 0, "R5 BL4 ilv");
    burst('h1F6, 3'd3, 1, 0, 0, 0, 0, "R5 BL8 ilv");
    burst('h0D5, 3'd1, 1, 0, 0, 0, 0, "R5 BL2 ilv");
    burst('h1F9, 3'd7, 0, 0, 0, 20, 1, "R7 page wrap");
    burst('h003, 3'd7, 1, 0, 0, 10, 1, "R7 page ilv ignored");
    burst('h0A3, 3'd3, 0, 0, 0, 3, 1, "R8 BL8 stop early");
    burst('h0A6, 3'd2, 1, 0, 0, 2, 1, "R8 BL4 ilv stop");
    burst('h055, 3'd3, 0, 1, 1, 0, 0, "R9 write single");
    burst('h055, 3'd2, 0, 0, 1, 0, 0, "R9 read keeps length");
    burst('h055, 3'd2, 0, 1, 0, 0, 0, "R9 write burst");
    burst('h07E, 3'd5, 0, 0, 0, 0, 0, "R3 reserved code");
    monEn = 1'b0;

    // R11: hold without advance
    @(negedge clk);
    startCol = COL_W'('h0AA); blSel = 3'd3; ilvSel = 1'b0; isWrite = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(colValid && colOut == COL_W'('h0AA), "R11 hold", int'(colOut), 'h0AA);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(colValid == 1'b0, "R8 stop after hold", int'(colValid), 0);

    // R2: restart during a running burst, with advance also high
    startCol = COL_W'('h040); blSel = 3'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    advance = 1'b1;
    repeat (2) @(negedge clk);
    chk(colOut == COL_W'('h042), "R4 before restart", int'(colOut), 'h042);
    startCol = COL_W'('h123); blSel = 3'd2; stop = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    advance = 1'b0;
    chk(colValid == 1'b1, "R2 restart valid", int'(colValid), 1);
    chk(colOut == COL_W'('h123), "R2 restart col", int'(colOut), 'h123);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(colValid == 1'b0, "R8 stop after restart", int'(colValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule